// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Realigner

This block sits between a word-aligned fetch port that delivers 32 bits per beat and an instruction decoder. Instructions are either 16 or 32 bits long and may begin on any halfword boundary. A 32-bit instruction can therefore be split across two fetch words. The block finds the length of each instruction, holds a leftover upper halfword when needed, and reassembles instructions that cross a word boundary. It hands the decoder one whole instruction per cycle, together with its address, the address of the following instruction and a compressed flag, over a valid/ready handshake.

The block owns the fetch address. It publishes the index of the next word it wants, and the fetch side answers with that word under valid/ready. A redirect loads a new instruction address, which may point at the upper halfword of a word. The redirect discards any buffered halfword and restarts both the fetch index and the instruction address. No misaligned condition is ever signalled.

Top module: `hw_realign`

## Requirements
- R1: The length of an instruction is set by bits 1:0 of its first halfword. The value 2'b11 means 32 bits, with `out_compressed` low. Any other value means 16 bits, with `out_compressed` high. For a 16-bit instruction, `out_instr[31:16]` is zero.
- R2: `out_next_pc` equals `out_pc + 2` for a 16-bit instruction and `out_pc + 4` for a 32-bit one.
- R3: Without a redirect, each accepted instruction is followed by an instruction whose `out_pc` is the `out_next_pc` of the one before.
- R4: In a redirect cycle, `out_valid` and `fw_ready` are both low. In the next cycle, `out_pc` equals `redir_pc` with bit 0 forced to zero, and `fetch_word` equals `redir_pc[ADDR_W-1:2]`. Any buffered halfword is dropped.
- R5: When `redir_pc[1]` is 1, the lower halfword of the first word fetched afterwards is discarded. The first instruction comes from that word's upper halfword.
- R6: A 32-bit instruction that starts in an upper halfword is emitted with that halfword as bits 15:0 and the lower halfword of the next fetch word as bits 31:16.
- R7: When one fetch word holds two 16-bit instructions, they take two output cycles. `fw_ready` stays low while the buffered second one is pending. After every accepted instruction ending at byte address E, exactly ceil(E/4) − (start address/4) words have been taken since the last redirect.
- R8: `out_illegal` is high exactly when the first halfword of the instruction is 16'h0000 or 16'hFFFF. The instruction is still passed on.
- R9: `out_valid` is never high while a 32-bit instruction is still waiting for its second half. Whenever `out_valid` is high, `out_instr` holds the complete instruction at `out_pc`.
- R10: After reset, `out_pc` is `RESET_PC`, `fetch_word` is `RESET_PC[ADDR_W-1:2]` and `out_valid` is low while `fw_valid` is low.
- R11: While `out_valid` is high and `out_ready` is low, with no redirect, `out_pc` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Load a new instruction address |
| redir_pc | input | ADDR_W | Redirect target byte address; bit 0 ignored |
| fetch_word | output | ADDR_W-2 | Index of the next fetch word wanted |
| fw_valid | input | 1 | Fetch word present |
| fw_data | input | 32 | Fetch word, lower halfword at the lower address |
| fw_ready | output | 1 | Fetch word taken this cycle |
| out_valid | output | 1 | Instruction present |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 32 | Whole instruction, first halfword in bits 15:0 |
| out_pc | output | ADDR_W | Address of the instruction |
| out_next_pc | output | ADDR_W | Address of the following instruction (link value) |
| out_compressed | output | 1 | Instruction is 16 bits |
| out_illegal | output | 1 | First halfword is all zeros or all ones |

## Verification
Every output is combinational from the registered state and the fetch word of the same cycle. So the bench drives on the falling edge and samples the same cycle one time step later. An instruction is compared against the model in the cycle it is offered, not one cycle later. The redirect effects on `out_pc` and `fetch_word` appear after exactly one rising edge, and the bench looks for them in the following sample. The count of fetch words taken is compared at the moment each instruction is accepted, including a word taken in that same cycle.

// File: rtl/rlgn_pkg.sv
package rlgn_pkg;

   localparam int HW_W   = 16;
   localparam int WORD_W = 32;

   // a halfword whose two low bits are both set opens a 32-bit instruction
   function automatic logic hw_opens_full(input logic [HW_W-1:0] hw);
      return hw[1:0] == 2'b11;
   endfunction

   function automatic logic hw_is_bad(input logic [HW_W-1:0] hw);
      return (hw == '0) || (hw == '1);
   endfunction

endpackage

// File: rtl/rlgn_len_dec.sv
module rlgn_len_dec
   import rlgn_pkg::*;
(
   input  logic [HW_W-1:0] hw,
   output logic            full,
   output logic            bad
);

   assign full = hw_opens_full(hw);
   assign bad  = hw_is_bad(hw);

endmodule

// File: rtl/rlgn_hold.sv
module rlgn_hold
   import rlgn_pkg::*;
#(
   parameter bit RESET_ODD = 1'b0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            redir_valid,
   input  logic            redir_odd,
   input  logic            load,
   input  logic [HW_W-1:0] load_hw,
   input  logic            clr,
   input  logic            clr_skip,
   output logic [HW_W-1:0] hold_q,
   output logic            hold_v,
   output logic            skip_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         hold_v <= 1'b0;
         skip_q <= RESET_ODD;
      end else if (redir_valid) begin
         hold_v <= 1'b0;
         skip_q <= redir_odd;
      end else begin
         if (load) begin
            hold_q <= load_hw;
            hold_v <= 1'b1;
         end else if (clr) begin
            hold_v <= 1'b0;
         end
         if (clr_skip) skip_q <= 1'b0;
      end
   end

   // R5
   skip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> !hold_v);

endmodule

// File: rtl/rlgn_pc_seq.sv
module rlgn_pc_seq #(
   parameter int          ADDR_W   = 16,
   parameter logic [63:0] RESET_PC = '0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                redir_valid,
   input  logic [ADDR_W-1:0]   redir_pc,
   input  logic                out_fire,
   input  logic                out_full,
   input  logic                fetch_fire,
   output logic [ADDR_W-1:0]   pc_q,
   output logic [ADDR_W-1:0]   next_pc,
   output logic [ADDR_W-3:0]   word_q
);

   localparam int WIDX_W = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] PC0 = RESET_PC[ADDR_W-1:0];

   assign next_pc = pc_q + (out_full ? ADDR_W'(4) : ADDR_W'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= {PC0[ADDR_W-1:1], 1'b0};
         word_q <= PC0[ADDR_W-1:2];
      end else if (redir_valid) begin
         pc_q   <= {redir_pc[ADDR_W-1:1], 1'b0};
         word_q <= redir_pc[ADDR_W-1:2];
      end else begin
         if (out_fire)   pc_q   <= next_pc;
         if (fetch_fire) word_q <= word_q + WIDX_W'(1);
      end
   end

   // R4
   redir_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (pc_q == {$past(redir_pc[ADDR_W-1:1]), 1'b0})
                      && (word_q == $past(redir_pc[ADDR_W-1:2])));

endmodule

// File: rtl/hw_realign.sv
module hw_realign
   import rlgn_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [63:0] RESET_PC = '0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                redir_valid,
   input  logic [ADDR_W-1:0]   redir_pc,
   output logic [ADDR_W-3:0]   fetch_word,
   input  logic                fw_valid,
   input  logic [WORD_W-1:0]   fw_data,
   output logic                fw_ready,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_instr,
   output logic [ADDR_W-1:0]   out_pc,
   output logic [ADDR_W-1:0]   out_next_pc,
   output logic                out_compressed,
   output logic                out_illegal
);

   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_width
      $error("hw_realign: ADDR_W must lie in 4..64");
   end
   if (RESET_PC[0] != 1'b0) begin : g_bad_reset
      $error("hw_realign: RESET_PC must be halfword aligned");
   end

   logic [HW_W-1:0] hold_q, first_hw, load_hw;
   logic            hold_v, skip_q, first_full, first_bad;
   logic            load, clr, clr_skip, out_fire, fetch_fire;

   assign first_hw = hold_v ? hold_q
                   : (skip_q ? fw_data[31:16] : fw_data[15:0]);

   rlgn_len_dec u_dec (
      .hw   (first_hw),
      .full (first_full),
      .bad  (first_bad)
   );

   always_comb begin
      out_valid = 1'b0;
      fw_ready  = 1'b0;
      out_instr = '0;
      load_hw   = fw_data[31:16];
      if (redir_valid) begin
         out_valid = 1'b0;
      end else if (hold_v) begin
         if (!first_full) begin
            out_valid = 1'b1;
            out_instr = {16'h0000, hold_q};
         end else begin
            out_valid = fw_valid;
            out_instr = {fw_data[15:0], hold_q};
            fw_ready  = out_ready;
         end
      end else if (skip_q) begin
         if (!first_full) begin
            out_valid = fw_valid;
            out_instr = {16'h0000, fw_data[31:16]};
            fw_ready  = out_ready;
         end else begin
            fw_ready  = 1'b1;
         end
      end else begin
         out_valid = fw_valid;
         fw_ready  = out_ready;
         out_instr = first_full ? fw_data : {16'h0000, fw_data[15:0]};
      end
   end

   assign out_fire   = out_valid && out_ready;
   assign fetch_fire = fw_valid && fw_ready;
   // the upper half of a taken word is kept unless it was the instruction itself
   assign load       = fetch_fire && !(skip_q && !first_full)
                       && !(!hold_v && !skip_q && first_full);
   assign clr        = hold_v && !first_full && out_fire;
   assign clr_skip   = skip_q && fetch_fire;

   rlgn_hold #(.RESET_ODD(RESET_PC[1])) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .redir_valid (redir_valid),
      .redir_odd   (redir_pc[1]),
      .load        (load),
      .load_hw     (load_hw),
      .clr         (clr),
      .clr_skip    (clr_skip),
      .hold_q      (hold_q),
      .hold_v      (hold_v),
      .skip_q      (skip_q)
   );

   rlgn_pc_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
      .clk         (clk),
      .rst_n       (rst_n),
      .redir_valid (redir_valid),
      .redir_pc    (redir_pc),
      .out_fire    (out_fire),
      .out_full    (first_full),
      .fetch_fire  (fetch_fire),
      .pc_q        (out_pc),
      .next_pc     (out_next_pc),
      .word_q      (fetch_word)
   );

   assign out_compressed = !first_full;
   assign out_illegal    = first_bad;

   // R1
   len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_compressed == (out_instr[1:0] != 2'b11)));

   // R3
   pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && !redir_valid) |=> (out_pc == $past(out_next_pc)));

   // R4
   redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (!out_valid && !fw_ready));

   // R7
   drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && !first_full) |-> !fw_ready);

   // R8
   illegal_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_instr[15:0] == 16'h0000)) |-> out_illegal);

   // R9
   split_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_v && skip_q && first_full) |-> !out_valid);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !redir_valid) |=> $stable(out_pc));

endmodule

// File: tb/hw_realign_bench.sv
module hw_realign_bench;

   localparam int PERIOD = 10;
   localparam int AW     = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            redir_valid = 1'b0;
   logic [AW-1:0]   redir_pc = '0;
   logic [AW-3:0]   fetch_word;
   logic            fw_valid = 1'b0;
   logic [31:0]     fw_data = '0;
   logic            fw_ready;
   logic            out_valid;
   logic            out_ready = 1'b0;
   logic [31:0]     out_instr;
   logic [AW-1:0]   out_pc, out_next_pc;
   logic            out_compressed, out_illegal;

   hw_realign #(.ADDR_W(AW), .RESET_PC(64'd0)) u_hw_realign (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
      .fetch_word(fetch_word), .fw_valid(fw_valid), .fw_data(fw_data),
      .fw_ready(fw_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_instr(out_instr), .out_pc(out_pc), .out_next_pc(out_next_pc),
      .out_compressed(out_compressed), .out_illegal(out_illegal)
   );

   always #(PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0, fcount = 0, mstart = 0;
   logic [AW-1:0] mpc = '0;
   bit first_out = 1'b1, chk_word = 1'b0;

   function automatic logic [15:0] half_at(input int i);
      logic [31:0] v;
      if (i % 37 == 5) return 16'h0000;
      if (i % 41 == 9) return 16'hFFFF;
      v = i * 40503 + 7;
      v = v ^ (v >> 7);
      return v[15:0];
   endfunction

   function automatic bit coin(input int n);
      logic [31:0] v;
      v = n * 1103515245 + 12345;
      return v[17:16] != 2'b00;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit rv, input logic [AW-1:0] rpc, input bit fv, input bit rd);
      logic [15:0] h0;
      logic [31:0] e_instr;
      logic [AW-1:0] e_next;
      bit full;
      int e_words;
      @(negedge clk);
      cyc++;
      if (chk_word) begin
         check(fetch_word == (AW-2)'(mstart), "R4", "fetch_word after redirect",
               32'(fetch_word), 32'(mstart));
         chk_word = 1'b0;
      end
      redir_valid = rv;
      redir_pc    = rpc;
      fw_valid    = fv;
      out_ready   = rd;
      fw_data     = {half_at(2*int'(fetch_word)+1), half_at(2*int'(fetch_word))};
      #1;
      if (rv) begin
         check(!out_valid && !fw_ready, "R4", "quiet in redirect cycle",
               {30'd0, out_valid, fw_ready}, 32'd0);
         mpc = {rpc[AW-1:1], 1'b0};
         mstart = int'(rpc[AW-1:2]);
         fcount = 0;
         first_out = 1'b1;
         chk_word = 1'b1;
         return;
      end
      if (fw_valid && fw_ready) fcount++;
      if (out_valid) begin
         h0 = half_at(int'(mpc >> 1));
         full = h0[1:0] == 2'b11;
         e_instr = full ? {half_at(int'(mpc >> 1) + 1), h0} : {16'h0000, h0};
         e_next = mpc + (full ? AW'(4) : AW'(2));
         check(out_instr == e_instr, (full && mpc[1]) ? "R6" : "R9", "instr",
               out_instr, e_instr);
         check(out_pc == mpc, first_out ? (mpc[1] ? "R5" : "R4")
                              : (out_ready ? "R3" : "R11"), "pc",
               32'(out_pc), 32'(mpc));
         check(out_compressed == !full, "R1", "compressed flag",
               32'(out_compressed), 32'(!full));
         check(out_next_pc == e_next, "R2", "next pc", 32'(out_next_pc), 32'(e_next));
         check(out_illegal == (h0 == 16'h0000 || h0 == 16'hFFFF), "R8", "illegal",
               32'(out_illegal), 32'(h0 == 16'h0000 || h0 == 16'hFFFF));
         if (out_ready) begin
            e_words = (int'(e_next) + 3) / 4 - mstart;
            check(fcount == e_words, "R7", "words taken", 32'(fcount), 32'(e_words));
            mpc = e_next;
            first_out = 1'b0;
         end
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL R3 watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10
      check(out_pc == '0, "R10", "reset pc", 32'(out_pc), 32'd0);
      check(fetch_word == '0, "R10", "reset fetch word", 32'(fetch_word), 32'd0);
      check(!out_valid, "R10", "reset valid", 32'(out_valid), 32'd0);
      // run from reset address, full throughput then with stalls
      for (int k = 0; k < 200; k++) step(1'b0, '0, 1'b1, 1'b1);
      for (int k = 0; k < 400; k++) step(1'b0, '0, coin(cyc * 3 + 1), coin(cyc * 7 + 2));
      // redirect sweep over halfword targets, some with bit 0 set
      for (int t = 0; t < 160; t++) begin
         logic [AW-1:0] tgt;
         tgt = AW'(600 + t * 2 + ((t % 5 == 3) ? 1 : 0));
         step(1'b1, tgt, 1'b1, 1'b1);
         for (int k = 0; k < 10; k++) step(1'b0, '0, coin(cyc * 5 + t), coin(cyc * 11 + 3));
         for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b1, 1'b1);
      end
      // back-to-back redirects and one during a stalled straddle
      step(1'b1, AW'(3003), 1'b1, 1'b1);
      step(1'b1, AW'(4002), 1'b1, 1'b1);
      for (int k = 0; k < 3000; k++) step(1'b0, '0, coin(cyc * 13 + 5), coin(cyc * 17 + 9));
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule